// File: doc/BRIEF.md
# Framed duty-coded bus master timing generator

This block is the digital half of one channel of a two-wire-controlled sensor bus master. It drives a physical-layer transceiver through two logic lines, a frame line (F, active low while a message is on the wire) and a signal line (S). It listens to a single return line (R) on which the transceiver reports the current drawn by the slaves. The host gives a message word, a bit count and a cycle time in clock ticks, then pulses a start strobe. The block builds the frame envelope, codes each bit by the share of the cycle during which S is held high, and shifts the returned bits into a response word. It pulses done when the frame closes.

When no message is on the wire, R is expected to stay low. If R reads high while F has been high for more than one cycle, the transmitter has shut itself down because of over-temperature or current limiting. The block then raises a sticky fault flag. A cycle time below the legal minimum is raised to that minimum, and a flag records the correction. A chip with two channels uses two instances.

Top module: `dsi_master_tg`

## Requirements
- R1: After reset, frame_n is 1 and sig is 0 (high-impedance code), and busy, done, fault and cyc_err are 0. This state holds until the first accepted start.
- R2: Between transfers, frame_n and sig are both 1 (idle code). sig never changes in a cycle where frame_n is 1 and was 1 in the cycle before.
- R3: An accepted start drives frame_n to 0 with sig 0 in the next cycle. The first rise of sig comes exactly C ticks after frame_n falls, where C is the effective cycle time.
- R4: The message is the N = len_m1+1 low bits of tx_word, sent most significant first. Each bit takes C ticks, with sig high first and then low. A 0 holds sig high for floor((C+1)/3) ticks and a 1 holds it for floor((2C+1)/3) ticks.
- R5: After the low phase of the last bit, frame_n stays 0 with sig 0 for TAIL_TICKS more ticks. Then frame_n and sig return to 1 in the same cycle.
- R6: R is sampled at every falling edge of sig except the first, and at the rising edge of frame_n, using the value held in the cycle before that edge. The N samples fill rx_word[N-1:0], the first sample landing in bit N-1. The upper bits are 0.
- R7: busy is 1 exactly while frame_n is 0. done is 1 for exactly one cycle, the first cycle in which frame_n is back at 1.
- R8: A start pulse while busy is 1 is ignored: the transfer's timing, response and cyc_err stay as they were.
- R9: When cyc_ticks is below MIN_CYC at an accepted start, MIN_CYC is used and cyc_err becomes 1. Otherwise cyc_ticks is used and cyc_err becomes 0. cyc_err holds until the next accepted start.
- R10: If ret_in is 1 in a cycle where frame_n is 1 and was also 1 in the cycle before, fault is 1 from the next cycle on. It stays 1 until the next accepted start clears it, and a response obtained while fault is 1 is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start strobe, accepted only when not busy |
| tx_word | input | 32 | Message, low N bits sent MSB first |
| len_m1 | input | 5 | Message length minus one |
| cyc_ticks | input | 18 | Requested bit cycle time in clock ticks |
| ret_in | input | 1 | Return line from the transceiver |
| frame_n | output | 1 | Frame line, low during a message |
| sig | output | 1 | Signal line carrying the duty-coded bits |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| rx_word | output | 32 | Captured response word |
| fault | output | 1 | Sticky transmitter-limit fault |
| cyc_err | output | 1 | Requested cycle time was clamped |

## Verification
Directed transfers cover the extremes: a single-bit message at the minimum cycle time, a 32-bit alternating pattern that exercises every slot, and requests of zero and just below the minimum. These requests separate the clamped case from the exact-minimum case. Constrained-random messages with random lengths, cycle times around the minimum and random slave replies check the high times bit by bit. Any mix-up between the zero and one durations, any misaligned shift, or an off-by-one in the lead or tail phase makes the measured phase lengths or the response word differ. A start pulse injected mid-frame with different data shows whether the strobe is really ignored. Driving R high during the high-impedance and idle phases shows that the fault flag is set there and is cleared by the next start.

// File: rtl/dsi_tg_pkg.sv
package dsi_tg_pkg;

    localparam int unsigned TG_CYC_W  = 18;
    localparam int unsigned TG_MAXB   = 32;
    localparam int unsigned TG_LEN_W  = $clog2(TG_MAXB);

    typedef enum logic [2:0] {
        ST_HIZ,
        ST_IDLE,
        ST_LEAD,
        ST_HIGH,
        ST_LOW,
        ST_TAIL
    } phase_e;

    typedef struct packed {
        logic [TG_CYC_W-1:0] cyc;
        logic [TG_CYC_W-1:0] hi0;
        logic [TG_CYC_W-1:0] hi1;
    } bit_timing_t;

    function automatic logic [TG_CYC_W:0] div_by3(input logic [TG_CYC_W:0] v);
        return v / (TG_CYC_W+1)'(3);
    endfunction

endpackage

// File: rtl/dsi_tg_cfg.sv
module dsi_tg_cfg
    import dsi_tg_pkg::*;
#(
    parameter int unsigned MIN_CYC = 1650
) (
    input  logic [TG_CYC_W-1:0] cyc_req,
    output bit_timing_t         tim,
    output logic                too_short
);
    localparam logic [TG_CYC_W-1:0] MIN_V = TG_CYC_W'(MIN_CYC);

    logic [TG_CYC_W-1:0] c_eff;
    logic [TG_CYC_W:0]   c_ext;

    always_comb begin
        too_short = (cyc_req < MIN_V);
        c_eff     = too_short ? MIN_V : cyc_req;
        c_ext     = {1'b0, c_eff};
        tim.cyc   = c_eff;
        tim.hi0   = TG_CYC_W'(div_by3(c_ext + 1'b1));
        tim.hi1   = TG_CYC_W'(div_by3((c_ext << 1) + 1'b1));
    end
endmodule

// File: rtl/dsi_tg_seq.sv
module dsi_tg_seq
    import dsi_tg_pkg::*;
#(
    parameter int unsigned TAIL_TICKS = 250
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic [31:0]         tx_word,
    input  logic [TG_LEN_W-1:0] len_m1,
    input  bit_timing_t         tim_in,
    input  logic                too_short,
    output logic                frame_n,
    output logic                sig,
    output logic                busy,
    output logic                done,
    output logic                cyc_err,
    output logic                accept,
    output logic                cap_fall,
    output logic                cap_rise
);
    localparam logic [TG_CYC_W-1:0] TAIL_LD = TG_CYC_W'(TAIL_TICKS - 1);

    phase_e              st;
    logic [TG_CYC_W-1:0] cnt;
    bit_timing_t         tim_q;
    logic [31:0]         tx_sh;
    logic [TG_LEN_W-1:0] left;
    logic                first_q;
    logic                tick_end;
    logic [TG_CYC_W-1:0] h_cur;
    logic [TG_CYC_W-1:0] h_nxt;

    always_comb begin
        tick_end = (cnt == '0);
        h_cur    = tx_sh[31] ? tim_q.hi1 : tim_q.hi0;
        h_nxt    = tx_sh[30] ? tim_q.hi1 : tim_q.hi0;
        accept   = start && (st == ST_HIZ || st == ST_IDLE);
        frame_n  = (st == ST_HIZ) || (st == ST_IDLE);
        sig      = (st == ST_IDLE) || (st == ST_HIGH);
        busy     = !frame_n;
        cap_fall = (st == ST_HIGH) && tick_end && !first_q;
        cap_rise = (st == ST_TAIL) && tick_end;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_HIZ;
            cnt     <= '0;
            tim_q   <= '0;
            tx_sh   <= '0;
            left    <= '0;
            first_q <= 1'b1;
            done    <= 1'b0;
            cyc_err <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (st)
                ST_HIZ, ST_IDLE: begin
                    if (start) begin
                        st      <= ST_LEAD;
                        cnt     <= tim_in.cyc - 1'b1;
                        tim_q   <= tim_in;
                        tx_sh   <= tx_word << (5'd31 - len_m1);
                        left    <= len_m1;
                        first_q <= 1'b1;
                        cyc_err <= too_short;
                    end
                end
                ST_LEAD: begin
                    if (tick_end) begin
                        st  <= ST_HIGH;
                        cnt <= h_cur - 1'b1;
                    end else cnt <= cnt - 1'b1;
                end
                ST_HIGH: begin
                    if (tick_end) begin
                        st      <= ST_LOW;
                        cnt     <= tim_q.cyc - h_cur - 1'b1;
                        first_q <= 1'b0;
                    end else cnt <= cnt - 1'b1;
                end
                ST_LOW: begin
                    if (tick_end) begin
                        if (left == '0) begin
                            st  <= ST_TAIL;
                            cnt <= TAIL_LD;
                        end else begin
                            st    <= ST_HIGH;
                            left  <= left - 1'b1;
                            tx_sh <= tx_sh << 1;
                            cnt   <= h_nxt - 1'b1;
                        end
                    end else cnt <= cnt - 1'b1;
                end
                ST_TAIL: begin
                    if (tick_end) begin
                        st   <= ST_IDLE;
                        done <= 1'b1;
                    end else cnt <= cnt - 1'b1;
                end
                default: st <= ST_HIZ;
            endcase
        end
    end
endmodule

// File: rtl/dsi_tg_rx.sv
module dsi_tg_rx
    import dsi_tg_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        clear,
    input  logic        cap_fall,
    input  logic        cap_rise,
    input  logic        ret_in,
    input  logic        frame_n,
    output logic [31:0] rx_word,
    output logic        fault
);
    logic f_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_word <= '0;
            fault   <= 1'b0;
            f_prev  <= 1'b1;
        end else begin
            f_prev <= frame_n;
            if (clear)
                rx_word <= '0;
            else if (cap_fall || cap_rise)
                rx_word <= {rx_word[30:0], ret_in};
            if (clear)
                fault <= 1'b0;
            else if (frame_n && f_prev && ret_in)
                fault <= 1'b1;
        end
    end
endmodule

// File: rtl/dsi_master_tg.sv
module dsi_master_tg
    import dsi_tg_pkg::*;
#(
    parameter int unsigned MIN_CYC    = 1650,
    parameter int unsigned TAIL_TICKS = 250
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic [31:0]         tx_word,
    input  logic [TG_LEN_W-1:0] len_m1,
    input  logic [TG_CYC_W-1:0] cyc_ticks,
    input  logic                ret_in,
    output logic                frame_n,
    output logic                sig,
    output logic                busy,
    output logic                done,
    output logic [31:0]         rx_word,
    output logic                fault,
    output logic                cyc_err
);
    bit_timing_t tim;
    logic        too_short;
    logic        accept;
    logic        cap_fall;
    logic        cap_rise;

    dsi_tg_cfg #(.MIN_CYC(MIN_CYC)) u_cfg (
        .cyc_req   (cyc_ticks),
        .tim       (tim),
        .too_short (too_short)
    );

    dsi_tg_seq #(.TAIL_TICKS(TAIL_TICKS)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .tx_word   (tx_word),
        .len_m1    (len_m1),
        .tim_in    (tim),
        .too_short (too_short),
        .frame_n   (frame_n),
        .sig       (sig),
        .busy      (busy),
        .done      (done),
        .cyc_err   (cyc_err),
        .accept    (accept),
        .cap_fall  (cap_fall),
        .cap_rise  (cap_rise)
    );

    dsi_tg_rx u_rx (
        .clk      (clk),
        .rst      (rst),
        .clear    (accept),
        .cap_fall (cap_fall),
        .cap_rise (cap_rise),
        .ret_in   (ret_in),
        .frame_n  (frame_n),
        .rx_word  (rx_word),
        .fault    (fault)
    );
endmodule

// File: rtl/dsi_master_tg_chk.sv
module dsi_master_tg_chk
    import dsi_tg_pkg::*;
#(
    parameter int unsigned MIN_CYC = 1650
) (
    input logic                clk,
    input logic                rst,
    input logic                start,
    input logic [TG_CYC_W-1:0] cyc_ticks,
    input logic                ret_in,
    input logic                frame_n,
    input logic                sig,
    input logic                busy,
    input logic                done,
    input logic                fault,
    input logic                cyc_err
);
    localparam logic [TG_CYC_W-1:0] MIN_V = TG_CYC_W'(MIN_CYC);

    // R1
    reset_state_chk: assert property (@(posedge clk)
        $fell(rst) |-> (frame_n && !sig && !busy && !done && !fault));

    // R2
    sig_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (frame_n && $past(frame_n)) |-> $stable(sig));

    // R3
    lead_low_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(frame_n) |-> !sig);

    // R7
    done_edge_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (frame_n && !$past(frame_n)));

    // R7
    rise_done_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(frame_n) |-> done);

    // R9
    clamp_flag_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> (cyc_err == ($past(cyc_ticks) < MIN_V)));

    // R10
    fault_set_chk: assert property (@(posedge clk) disable iff (rst)
        (frame_n && $past(frame_n) && ret_in && !start) |=> fault);
endmodule

bind dsi_master_tg dsi_master_tg_chk #(.MIN_CYC(MIN_CYC)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .cyc_ticks (cyc_ticks),
    .ret_in    (ret_in),
    .frame_n   (frame_n),
    .sig       (sig),
    .busy      (busy),
    .done      (done),
    .fault     (fault),
    .cyc_err   (cyc_err)
);

// File: tb/dsi_master_tg_bench.sv
module dsi_master_tg_bench;
    import dsi_tg_pkg::*;

    localparam int MINC = 12;
    localparam int TAIL = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [31:0] tx_word = '0;
    logic [4:0]  len_m1 = '0;
    logic [17:0] cyc_ticks = '0;
    logic        ret_in = 1'b0;
    logic        frame_n, sig, busy, done, fault, cyc_err;
    logic [31:0] rx_word;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    dsi_master_tg #(.MIN_CYC(MINC), .TAIL_TICKS(TAIL)) u_dsi_master_tg (
        .clk(clk), .rst(rst), .start(start), .tx_word(tx_word), .len_m1(len_m1),
        .cyc_ticks(cyc_ticks), .ret_in(ret_in), .frame_n(frame_n), .sig(sig),
        .busy(busy), .done(done), .rx_word(rx_word), .fault(fault), .cyc_err(cyc_err)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int eff_cyc(input int c);
        return (c < MINC) ? MINC : c;
    endfunction

    function automatic int hi_ticks(input int c, input bit b);
        return b ? (2 * c + 1) / 3 : (c + 1) / 3;
    endfunction

    function automatic logic [31:0] low_mask(input int n);
        return (n == 32) ? 32'hFFFF_FFFF : ((32'd1 << n) - 32'd1);
    endfunction

    task automatic xfer(input logic [31:0] word, input int lm1, input int cyc,
                        input logic [31:0] resp, input bit poke);
        int n = lm1 + 1;
        int c = eff_cyc(cyc);
        int lead = 0;
        int hi[32];
        int lo[32];
        int rises = 0;
        int falls = 0;
        int run = 0;
        int guard = 0;
        bit prev_s = 1'b0;
        bit t_ok = 1'b1;
        bit e_ok;
        logic [31:0] bw;
        for (int i = 0; i < 32; i++) begin hi[i] = 0; lo[i] = 0; end
        tx_word   = word;
        len_m1    = 5'(lm1);
        cyc_ticks = 18'(cyc);
        start     = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(frame_n == 1'b0 && sig == 1'b0, "R3", "frame start code", {frame_n, sig}, 0);
        check(busy == 1'b1, "R7", "busy at frame start", busy, 1);
        check(cyc_err == (cyc < MINC), "R9", "cyc_err", cyc_err, (cyc < MINC));
        check(fault == 1'b0, "R10", "fault cleared by start", fault, 0);
        e_ok = (cyc < MINC);
        while (frame_n == 1'b0 && guard < 100000) begin
            if (sig != prev_s) begin
                if (prev_s == 1'b0) begin
                    if (rises == 0) lead = run;
                    else if (rises <= 32) lo[rises-1] = run;
                    rises++;
                end else begin
                    if (rises >= 1 && rises <= 32) hi[rises-1] = run;
                    falls++;
                    if (falls <= n) ret_in = resp[n - falls];
                end
                run = 0;
            end
            run++;
            prev_s = sig;
            if (poke && guard == 5) begin
                start     = 1'b1;
                tx_word   = ~word;
                len_m1    = 5'(31 - lm1);
                cyc_ticks = (cyc < MINC) ? 18'(MINC + 7) : 18'd3;
            end else start = 1'b0;
            @(negedge clk);
            guard++;
        end
        start = 1'b0;
        if (rises >= 1 && rises <= 32) lo[rises-1] = run;
        check(sig == 1'b1 && frame_n == 1'b1, "R5", "F and S return high together", {frame_n, sig}, 3);
        check(done == 1'b1, "R7", "done in first F-high cycle", done, 1);
        check(busy == 1'b0, "R7", "busy low after frame", busy, 0);
        check(rx_word == (resp & low_mask(n)), "R6", "response word", rx_word, resp & low_mask(n));
        check(cyc_err == e_ok, poke ? "R8" : "R9", "cyc_err held", cyc_err, e_ok);
        ret_in = 1'b0;
        check(lead == c, "R3", "lead ticks", lead, c);
        check(rises == n, poke ? "R8" : "R4", "bit count", rises, n);
        bw = word & low_mask(n);
        for (int i = 0; i < n && i < 32; i++) begin
            bit b = bw[n - 1 - i];
            int h = hi_ticks(c, b);
            int l = c - h + ((i == n - 1) ? TAIL : 0);
            if (hi[i] != h || lo[i] != l) begin
                if (t_ok)
                    $display("FAIL %s bit %0d timing: actual hi %0d lo %0d expected hi %0d lo %0d",
                             (i == n - 1) ? "R5" : "R4", i, hi[i], lo[i], h, l);
                t_ok = 1'b0;
            end
        end
        checks++;
        if (!t_ok) errors++;
        @(negedge clk);
        check(done == 1'b0, "R7", "done lasts one cycle", done, 0);
        check(frame_n == 1'b1 && sig == 1'b1, "R2", "idle code", {frame_n, sig}, 3);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL R7 watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(frame_n == 1'b1 && sig == 1'b0, "R1", "hi-Z code after reset", {frame_n, sig}, 2);
        check(!busy && !done && !fault && !cyc_err, "R1", "status after reset",
              {busy, done, fault, cyc_err}, 0);
        repeat (5) @(negedge clk);
        check(frame_n == 1'b1 && sig == 1'b0, "R1", "hi-Z held without start", {frame_n, sig}, 2);

        // R10 fault in the high-impedance state
        ret_in = 1'b1;
        @(negedge clk);
        ret_in = 1'b0;
        check(fault == 1'b1, "R10", "fault raised in hi-Z", fault, 1);
        @(negedge clk);
        check(fault == 1'b1, "R10", "fault sticky", fault, 1);

        // directed corner cases
        xfer(32'h1, 0, MINC, 32'h1, 1'b0);
        xfer(32'hAAAA_5555, 31, 20, 32'h3C3C_A5A5, 1'b0);
        xfer(32'h0000_0B, 4, MINC - 1, 32'h15, 1'b0);
        xfer(32'h0, 7, 0, 32'hFF, 1'b0);
        xfer(32'hFFFF_FFFF, 31, MINC, 32'h0, 1'b0);

        // R2 idle held over several cycles
        repeat (6) @(negedge clk);
        check(frame_n == 1'b1 && sig == 1'b1, "R2", "idle held", {frame_n, sig}, 3);

        // R8 start pokes while busy
        xfer(32'h0000_1234, 15, 18, 32'h0000_BEEF, 1'b1);
        xfer(32'h5, 2, 5, 32'h6, 1'b1);

        // R10 fault in idle, cleared by next start
        @(negedge clk);
        ret_in = 1'b1;
        @(negedge clk);
        ret_in = 1'b0;
        check(fault == 1'b1, "R10", "fault raised in idle", fault, 1);
        xfer(32'h3, 1, 16, 32'h2, 1'b0);

        // constrained random transfers
        for (int k = 0; k < 24; k++) begin
            logic [31:0] w = $urandom;
            logic [31:0] r = $urandom;
            int l = $urandom_range(0, 31);
            int cy = $urandom_range(MINC - 4, 40);
            xfer(w, l, cy, r, (k % 5) == 3);
        end

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule